// File: doc/BRIEF.md
# Strobed Parallel Register Bus Slave

This block is a register slave for a processor that has only plain general-purpose parallel outputs and inputs. The processor writes an 11-bit control word and a 32-bit data word, and it reads back a 32-bit result word. Each access is a software handshake. The processor first sets an enable bit with the address. Next it raises a strobe bit while the enable stays set. Then it drops the strobe. The slave synchronises the control word into its own clock domain and decodes exactly one access per rising edge of the strobe.

Behind the bus sits a small register map:

- a system control register holding two mode bits and a self-clearing reset request;
- an exposure time register in microseconds;
- a measurement control register with a self-clearing start request;
- an output register that drives two indicators;
- a read-only status word with the empty flags of three output queues.

Reading one of three queue addresses returns the oldest word of that queue and removes it. A test-side push port fills the queues.

Top module: `pio_reg_slave`

## Requirements
- R1: The control word carries the address in bits 7:0, read enable in bit 8, write enable in bit 9 and strobe in bit 10. An access happens only on a rising edge of the strobe, with its effect visible after the third clock edge after the strobe rises. A strobe held high, or a strobe with neither enable set, makes no further access.
- R2: On a write access, `wr_data` is stored into the addressed register. A write has priority if both enables are set.
- R3: On a read access, the addressed value appears on `rd_data` and stays unchanged until the next read access. Write accesses do not disturb it.
- R4: Register 0x01 keeps bits 5 and 4 as written and reads every other bit as zero. Bit 5 drives `sim_data_sel` and bit 4 drives `wide_data_sel`.
- R5: Writing 0x01 with bit 15 set gives a `logic_rst_pulse` exactly one clock long. Bit 15 reads back as zero.
- R6: Register 0x03 holds a 32-bit exposure time in microseconds (10000 = 10 ms), driven on `exposure_us`.
- R7: Register 0x10 holds measurement control, driven on `meas_cfg`. Writing bit 27 gives a one-clock `meas_start_pulse`. The bit then clears itself, and the other bits are kept.
- R8: Address 0x7F is a read-only status word. Bit 1 is set when the dark queue is empty, bit 3 when the raw queue is empty, and bit 5 when the calibrated queue is empty. All other bits read zero, and writes have no effect.
- R9: A read at 0x30, 0x31 or 0x32 returns the oldest word of the dark, raw or calibrated queue and removes it, in first-in first-out order. A read of an empty queue returns zero and removes nothing.
- R10: Register 0x81 is read/write. Its bit 31 drives `led_out[1]` and its bit 30 drives `led_out[0]`.
- R11: A read of an unmapped address returns zero, and a write to one changes nothing.
- R12: `q_push[i]` appends `q_push_data` to queue i (0 dark, 1 raw, 2 calibrated). A push to a full queue of FIFO_DEPTH words is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_word | input | 11 | Strobe, write enable, read enable and address |
| wr_data | input | 32 | Write data word |
| rd_data | output | 32 | Result of the last read access |
| q_push | input | 3 | Per-queue push request (test fill) |
| q_push_data | input | 32 | Word pushed into the selected queues |
| logic_rst_pulse | output | 1 | One-clock reset request to downstream logic |
| meas_start_pulse | output | 1 | One-clock measurement start request |
| sim_data_sel | output | 1 | Simulated data select |
| wide_data_sel | output | 1 | Data width select |
| exposure_us | output | 32 | Exposure time in microseconds |
| meas_cfg | output | 32 | Measurement control contents |
| led_out | output | 2 | Indicator outputs |

## Verification
A strobe rise that reaches the clock edge k gives its result after edge k+2: two synchroniser flops, then the registered decode. Read data, register outputs and pulses therefore change just after that third edge. One directed test drives the strobe at a falling edge and samples `exposure_us` 1 ns after the second and third rising edges, expecting the old value and then the new one. Every other check samples only after the bus task has waited several cycles past the strobe. The pulses are counted in every cycle, at falling edges, so each pulse is checked to last exactly one cycle without relying on a fixed sample time.

// File: rtl/pio_reg_pkg.sv
package pio_reg_pkg;
    localparam int CTL_W   = 11;
    localparam int ADDR_W  = 8;
    localparam int DATA_W  = 32;
    localparam int RE_BIT  = 8;
    localparam int WE_BIT  = 9;
    localparam int STB_BIT = 10;
    localparam int NUM_Q   = 3;

    localparam logic [ADDR_W-1:0] ADR_SYSCTL = 8'h01;
    localparam logic [ADDR_W-1:0] ADR_EXPO   = 8'h03;
    localparam logic [ADDR_W-1:0] ADR_MEAS   = 8'h10;
    localparam logic [ADDR_W-1:0] ADR_Q_BASE = 8'h30;
    localparam logic [ADDR_W-1:0] ADR_STATUS = 8'h7F;
    localparam logic [ADDR_W-1:0] ADR_LED    = 8'h81;

    localparam int SYS_RST_BIT   = 15;
    localparam int SYS_SIM_BIT   = 5;
    localparam int SYS_WIDE_BIT  = 4;
    localparam int MEAS_START_BIT = 27;

    typedef struct packed {
        logic              rd;
        logic              wr;
        logic [ADDR_W-1:0] addr;
    } access_t;
endpackage

// File: rtl/pio_ctl_sync.sv
module pio_ctl_sync
    import pio_reg_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CTL_W-1:0] ctl_i,
    output access_t          acc_o,
    output logic             fire_o
);
    localparam int LAST = STAGES - 1;

    logic [CTL_W-1:0] stage_q [STAGES];
    logic [CTL_W-1:0] stage_d [STAGES];
    logic             prev_q, prev_d;

    always_comb begin
        stage_d[0] = ctl_i;
        for (int i = 1; i < STAGES; i++) begin
            stage_d[i] = stage_q[i-1];
        end
        prev_d = stage_q[LAST][STB_BIT];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) begin
                stage_q[i] <= '0;
            end
            prev_q <= 1'b0;
        end else begin
            for (int i = 0; i < STAGES; i++) begin
                stage_q[i] <= stage_d[i];
            end
            prev_q <= prev_d;
        end
    end

    assign fire_o     = stage_q[LAST][STB_BIT] & ~prev_q;
    assign acc_o.rd   = stage_q[LAST][RE_BIT];
    assign acc_o.wr   = stage_q[LAST][WE_BIT];
    assign acc_o.addr = stage_q[LAST][ADDR_W-1:0];

    // One strobe rise gives one access cycle only
    assert_fire_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
        fire_o |=> !fire_o);
endmodule

// File: rtl/pio_fifo.sv
module pio_fifo #(
    parameter int DEPTH = 4,
    parameter int W     = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push_i,
    input  logic [W-1:0] push_data_i,
    input  logic         pop_i,
    output logic [W-1:0] head_o,
    output logic         empty_o
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [PTR_W-1:0]        wp;
        logic [PTR_W-1:0]        rp;
        logic [CNT_W-1:0]        cnt;
    } fifo_st_t;

    fifo_st_t st_q, st_d;
    logic     full, do_push, do_pop;

    assign full    = (st_q.cnt == CNT_FULL);
    assign empty_o = (st_q.cnt == '0);
    assign head_o  = st_q.mem[st_q.rp];

    always_comb begin
        st_d    = st_q;
        do_push = push_i && !full;
        do_pop  = pop_i && !empty_o;
        if (do_push) begin
            st_d.mem[st_q.wp] = push_data_i;
            st_d.wp = (st_q.wp == PTR_LAST) ? '0 : st_q.wp + PTR_W'(1);
        end
        if (do_pop) begin
            st_d.rp = (st_q.rp == PTR_LAST) ? '0 : st_q.rp + PTR_W'(1);
        end
        if (do_push && !do_pop) begin
            st_d.cnt = st_q.cnt + CNT_W'(1);
        end else if (do_pop && !do_push) begin
            st_d.cnt = st_q.cnt - CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // A push into a full queue is dropped
    assert_no_overflow_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push_i && !pop_i) |=> (st_q.cnt == $past(st_q.cnt)));

    // The decoder never removes from an empty queue
    assert_no_underflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        pop_i |-> !empty_o);
endmodule

// File: rtl/pio_reg_slave.sv
module pio_reg_slave
    import pio_reg_pkg::*;
#(
    parameter int FIFO_DEPTH  = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CTL_W-1:0]  ctl_word,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    input  logic [NUM_Q-1:0]  q_push,
    input  logic [DATA_W-1:0] q_push_data,
    output logic              logic_rst_pulse,
    output logic              meas_start_pulse,
    output logic              sim_data_sel,
    output logic              wide_data_sel,
    output logic [DATA_W-1:0] exposure_us,
    output logic [DATA_W-1:0] meas_cfg,
    output logic [1:0]        led_out
);
    typedef struct packed {
        logic [DATA_W-1:0] rd;
        logic [1:0]        sys;
        logic [DATA_W-1:0] expo;
        logic [DATA_W-1:0] meas;
        logic [DATA_W-1:0] led;
        logic              rst_pulse;
    } regs_t;

    regs_t             st_q, st_d;
    access_t           acc;
    logic              fire;
    logic [NUM_Q-1:0]  q_pop;
    logic [NUM_Q-1:0]  q_empty;
    logic [DATA_W-1:0] q_head [NUM_Q];
    logic [DATA_W-1:0] rd_val;

    pio_ctl_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .ctl_i  (ctl_word),
        .acc_o  (acc),
        .fire_o (fire)
    );

    for (genvar g = 0; g < NUM_Q; g++) begin : g_queue
        pio_fifo #(.DEPTH(FIFO_DEPTH), .W(DATA_W)) u_fifo (
            .clk         (clk),
            .rst_n       (rst_n),
            .push_i      (q_push[g]),
            .push_data_i (q_push_data),
            .pop_i       (q_pop[g]),
            .head_o      (q_head[g]),
            .empty_o     (q_empty[g])
        );
    end

    always_comb begin
        st_d                      = st_q;
        st_d.rst_pulse            = 1'b0;
        st_d.meas[MEAS_START_BIT] = 1'b0;
        q_pop                     = '0;
        rd_val                    = '0;
        if (fire && acc.wr) begin
            unique case (acc.addr)
                ADR_SYSCTL: begin
                    st_d.sys       = {wr_data[SYS_SIM_BIT], wr_data[SYS_WIDE_BIT]};
                    st_d.rst_pulse = wr_data[SYS_RST_BIT];
                end
                ADR_EXPO: st_d.expo = wr_data;
                ADR_MEAS: st_d.meas = wr_data;
                ADR_LED:  st_d.led  = wr_data;
                default: ;
            endcase
        end else if (fire && acc.rd) begin
            unique case (acc.addr)
                ADR_SYSCTL: begin
                    rd_val[SYS_SIM_BIT]  = st_q.sys[1];
                    rd_val[SYS_WIDE_BIT] = st_q.sys[0];
                end
                ADR_EXPO: rd_val = st_q.expo;
                ADR_MEAS: rd_val = st_q.meas;
                ADR_LED:  rd_val = st_q.led;
                ADR_STATUS: begin
                    for (int i = 0; i < NUM_Q; i++) begin
                        rd_val[2*i+1] = q_empty[i];
                    end
                end
                default: begin
                    for (int i = 0; i < NUM_Q; i++) begin
                        if (acc.addr == ADR_Q_BASE + ADDR_W'(i) && !q_empty[i]) begin
                            rd_val   = q_head[i];
                            q_pop[i] = 1'b1;
                        end
                    end
                end
            endcase
            st_d.rd = rd_val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_data          = st_q.rd;
    assign logic_rst_pulse  = st_q.rst_pulse;
    assign meas_start_pulse = st_q.meas[MEAS_START_BIT];
    assign sim_data_sel     = st_q.sys[1];
    assign wide_data_sel    = st_q.sys[0];
    assign exposure_us      = st_q.expo;
    assign meas_cfg         = st_q.meas;
    assign led_out          = st_q.led[DATA_W-1 -: 2];

    assert_rst_pulse_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        logic_rst_pulse |=> !logic_rst_pulse);

    assert_meas_pulse_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        meas_start_pulse |=> !meas_start_pulse);

    // Read data only moves on a read access
    assert_rd_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(fire && acc.rd && !acc.wr) |=> $stable(rd_data));

    // Only one queue is removed from per access
    assert_single_pop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(q_pop));
endmodule

// File: tb/pio_reg_slave_bench.sv
module pio_reg_slave_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 9;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [10:0] ctl_word = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic [2:0]  q_push = '0;
    logic [31:0] q_push_data = '0;
    logic        logic_rst_pulse, meas_start_pulse, sim_data_sel, wide_data_sel;
    logic [31:0] exposure_us, meas_cfg;
    logic [1:0]  led_out;

    int checks = 0;
    int errors = 0;
    int rst_cnt = 0;
    int meas_cnt = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pio_reg_slave u_pio_reg_slave (
        .clk(clk), .rst_n(rst_n), .ctl_word(ctl_word), .wr_data(wr_data),
        .rd_data(rd_data), .q_push(q_push), .q_push_data(q_push_data),
        .logic_rst_pulse(logic_rst_pulse), .meas_start_pulse(meas_start_pulse),
        .sim_data_sel(sim_data_sel), .wide_data_sel(wide_data_sel),
        .exposure_us(exposure_us), .meas_cfg(meas_cfg), .led_out(led_out)
    );

    // address, write data, expected read-back
    localparam logic [71:0] VEC [NVEC] = '{
        {8'h03, 32'h0000_2710, 32'h0000_2710},
        {8'h01, 32'h0000_0020, 32'h0000_0020},
        {8'h01, 32'hFFFF_7FFF, 32'h0000_0030},
        {8'h10, 32'h0000_0D00, 32'h0000_0D00},
        {8'h10, 32'h0800_0D30, 32'h0000_0D30},
        {8'h81, 32'hC000_0005, 32'hC000_0005},
        {8'h7F, 32'hFFFF_FFFF, 32'h0000_002A},
        {8'h55, 32'hDEAD_BEEF, 32'h0000_0000},
        {8'h30, 32'h1234_5678, 32'h0000_0000}
    };
    localparam string VEC_REQ [NVEC] = '{"R6", "R4", "R4", "R7", "R7", "R10", "R8", "R11", "R9"};

    always @(negedge clk) begin
        if (rst_n) begin
            if (logic_rst_pulse) rst_cnt++;
            if (meas_start_pulse) meas_cnt++;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp,
                         input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %08h expected %08h", req, what, act, exp);
        end
    endtask

    task automatic bus_op(input logic [7:0] a, input bit wr, input logic [31:0] d);
        wr_data  = d;
        ctl_word = {1'b0, wr, ~wr, a};
        repeat (3) @(negedge clk);
        ctl_word[10] = 1'b1;
        repeat (4) @(negedge clk);
        ctl_word[10] = 1'b0;
        repeat (3) @(negedge clk);
        ctl_word = '0;
        repeat (2) @(negedge clk);
    endtask

    task automatic push(input int q, input logic [31:0] d);
        q_push      = 3'(1 << q);
        q_push_data = d;
        @(negedge clk);
        q_push = '0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // reset state
        check("R3", rd_data, 32'h0, "reset rd_data");
        check("R6", exposure_us, 32'h0, "reset exposure");
        check("R10", {30'b0, led_out}, 32'h0, "reset leds");
        check("R5", {31'b0, logic_rst_pulse}, 32'h0, "reset pulse");
        bus_op(8'h7F, 1'b0, '0);
        check("R8", rd_data, 32'h0000_002A, "status after reset");

        // table: write then read back
        for (int i = 0; i < NVEC; i++) begin
            bus_op(VEC[i][71:64], 1'b1, VEC[i][63:32]);
            bus_op(VEC[i][71:64], 1'b0, '0);
            check(VEC_REQ[i], rd_data, VEC[i][31:0], "table read-back");
        end
        check("R4", {30'b0, sim_data_sel, wide_data_sel}, 32'h3, "mode outputs");
        check("R7", meas_cfg, 32'h0000_0D30, "meas_cfg after start");
        check("R7", meas_cnt, 1, "meas start pulse cycles");
        check("R6", exposure_us, 32'd10000, "exposure output");
        check("R10", {30'b0, led_out}, 32'h3, "leds from C0000005");
        bus_op(8'h81, 1'b1, 32'h8000_0000);
        check("R10", {30'b0, led_out}, 32'h2, "leds from 80000000");
        check("R11", exposure_us, 32'd10000, "unmapped write no effect");

        // self-clearing reset bit
        bus_op(8'h01, 1'b1, 32'h0000_8030);
        check("R5", rst_cnt, 1, "reset pulse cycles");
        bus_op(8'h01, 1'b0, '0);
        check("R5", rd_data, 32'h0000_0030, "bit 15 reads zero");

        // read hold across a write
        bus_op(8'h03, 1'b0, '0);
        bus_op(8'h81, 1'b1, 32'h4000_0000);
        check("R3", rd_data, 32'd10000, "rd_data held over write");

        // latency: effect after third edge
        wr_data  = 32'd100;
        ctl_word = {1'b0, 1'b1, 1'b0, 8'h03};
        repeat (3) @(negedge clk);
        ctl_word[10] = 1'b1;
        @(posedge clk);
        @(posedge clk);
        #1 check("R1", exposure_us, 32'd10000, "not yet after second edge");
        @(posedge clk);
        #1 check("R1", exposure_us, 32'd100, "written after third edge");
        // strobe held high: no further access
        @(negedge clk);
        wr_data = 32'd200;
        repeat (6) @(negedge clk);
        check("R1", exposure_us, 32'd100, "held strobe no rewrite");
        ctl_word[7:0] = 8'h81;
        wr_data = 32'h0;
        repeat (6) @(negedge clk);
        check("R1", {30'b0, led_out}, 32'h1, "held strobe new address");
        ctl_word = '0;
        repeat (3) @(negedge clk);
        // strobe without enables
        wr_data  = 32'd55;
        ctl_word = 11'h403;
        repeat (6) @(negedge clk);
        ctl_word = '0;
        repeat (3) @(negedge clk);
        check("R1", exposure_us, 32'd100, "strobe without enable");
        // both enables: write wins
        wr_data  = 32'd77;
        ctl_word = 11'h303;
        repeat (3) @(negedge clk);
        ctl_word[10] = 1'b1;
        repeat (4) @(negedge clk);
        ctl_word = '0;
        repeat (3) @(negedge clk);
        check("R2", exposure_us, 32'd77, "write priority");

        // queues: ordered pop
        push(1, 32'hA1);
        push(1, 32'hA2);
        push(1, 32'hA3);
        bus_op(8'h7F, 1'b0, '0);
        check("R8", rd_data, 32'h0000_0022, "raw not empty");
        bus_op(8'h31, 1'b0, '0);
        check("R9", rd_data, 32'hA1, "raw pop 1");
        bus_op(8'h31, 1'b0, '0);
        check("R9", rd_data, 32'hA2, "raw pop 2");
        bus_op(8'h31, 1'b0, '0);
        check("R9", rd_data, 32'hA3, "raw pop 3");
        bus_op(8'h31, 1'b0, '0);
        check("R9", rd_data, 32'h0, "raw empty read");
        bus_op(8'h7F, 1'b0, '0);
        check("R8", rd_data, 32'h0000_002A, "all empty again");

        // overflow on dark, calibrated untouched
        for (int i = 0; i < 5; i++) push(0, 32'hD0 + 32'(i));
        push(2, 32'hC7);
        for (int i = 0; i < 4; i++) begin
            bus_op(8'h30, 1'b0, '0);
            check("R12", rd_data, 32'hD0 + 32'(i), "dark pop in order");
        end
        bus_op(8'h30, 1'b0, '0);
        check("R12", rd_data, 32'h0, "fifth push dropped");
        bus_op(8'h32, 1'b0, '0);
        check("R9", rd_data, 32'hC7, "cal pop");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule